// File: doc/BRIEF.md
# PLL Retune Handover Sequencer

This block retunes the main CPU PLL without ever stopping the core clock. On a request it first parks the core clock mux on a fixed backup PLL and confirms the move through the mux status readback. It then programs the PLL lock-time count and writes the new multiplier, pre-divider and post-divider fields. Next it waits for the PLL to report lock. Finally it moves the mux back to the retuned PLL and confirms that move as well.

A controller issues a one-cycle `start` together with a level index from 0 to 4. It then waits for the one-cycle `done` pulse. Each level selects a fixed (M, P, S) triple: level 0 gives 1200 MHz, level 1 gives 1000 MHz, level 2 gives 800 MHz, level 3 gives 500 MHz and level 4 gives 200 MHz.

Every status wait is bounded by a timeout. On expiry the block raises an error flag, keeps the core on the backup PLL and returns to idle.

Top module: `pll_retune_seq`

## Requirements
- R1: After synchronous reset the block is idle: `busy`=0, `done`=0, `err`=0, `mux_to_backup`=0 (core on main PLL), `lock_count`=0 and `pll_ctrl`=`CTRL_INIT`.
- R2: An accepted request first sets `mux_to_backup`=1. `pll_ctrl` does not change until `mux_status` has read exactly 2 (backup selected).
- R3: `lock_count` is loaded with the `LOCK_TIME` parameter before the PLL fields of `pll_ctrl` are written.
- R4: The PLL word places M in bits 25:16, P in bits 13:8 and S in bits 2:0. Levels 0..4 give (M,P,S) = (150,3,1), (250,6,1), (200,6,1), (250,6,2) and (200,6,3). All other bits of `pll_ctrl` keep their previous value.
- R5: `mux_to_backup` returns to 0 only after `pll_locked` has read 1 following the PLL write.
- R6: `done` is a single-cycle pulse, given only after `mux_status` has read exactly 1 (main selected). `busy` is high from acceptance until the sequence ends.
- R7: A `start` while `busy` is high is ignored, and the sequence in flight completes with its own level.
- R8: A `start` with a level index above 4 is ignored: `busy` stays low and `pll_ctrl` is unchanged.
- R9: If any status wait exceeds `TIMEOUT` cycles, `err` is set, the block goes idle and the core is left on the backup PLL (`mux_to_backup`=1). The next accepted request clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle retune request |
| level | input | 3 | Target level index, 0..4 |
| mux_status | input | 3 | Core mux readback: 1 main, 2 backup |
| pll_locked | input | 1 | PLL lock status bit |
| mux_to_backup | output | 1 | Core mux select, 1 = backup PLL |
| lock_count | output | 16 | PLL lock-time count register |
| pll_ctrl | output | 32 | PLL control word with M, P and S fields |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status wait timed out |

## Verification
On every cycle, the assertions enforce the handover ordering: the PLL word changes only while parked and with the lock count loaded, the mux returns to main only after lock, done is a single pulse that follows a main-mux readback, an error always leaves the core parked, and a request is never taken while busy. The values written can only be shown by the bench's scenarios. These cover the exact M/P/S field contents, the preservation of the other control bits, the rejection of out-of-range levels, and recovery after stuck-mux and stuck-lock timeouts. The bench runs these against a stub PLL and mux over random and directed level sequences.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

    localparam int NUM_LEVELS = 5;
    localparam int LVL_W      = 3;
    localparam int CTRL_W     = 32;
    localparam int M_LSB      = 16;
    localparam int M_W        = 10;
    localparam int P_LSB      = 8;
    localparam int P_W        = 6;
    localparam int S_LSB      = 0;
    localparam int S_W        = 3;
    localparam int MUXST_W    = 3;

    localparam logic [MUXST_W-1:0] MUXST_MAIN   = 3'd1;
    localparam logic [MUXST_W-1:0] MUXST_BACKUP = 3'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PARK,
        ST_WAIT_BK,
        ST_LOCKT,
        ST_PMS,
        ST_WAIT_LOCK,
        ST_RETURN,
        ST_WAIT_MAIN
    } seq_state_t;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [P_W-1:0] p;
        logic [S_W-1:0] s;
    } pms_t;

    function automatic pms_t level_pms(input logic [LVL_W-1:0] lvl);
        pms_t r;
        case (lvl)
            3'd0:    r = '{m: 10'd150, p: 6'd3, s: 3'd1};
            3'd1:    r = '{m: 10'd250, p: 6'd6, s: 3'd1};
            3'd2:    r = '{m: 10'd200, p: 6'd6, s: 3'd1};
            3'd3:    r = '{m: 10'd250, p: 6'd6, s: 3'd2};
            default: r = '{m: 10'd200, p: 6'd6, s: 3'd3};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pll_pms_merge.sv
module pll_pms_merge
    import pll_retune_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_in,
    input  pms_t              pms,
    output logic [CTRL_W-1:0] ctrl_out
);
    always_comb begin
        ctrl_out = ctrl_in;
        ctrl_out[M_LSB +: M_W] = pms.m;
        ctrl_out[P_LSB +: P_W] = pms.p;
        ctrl_out[S_LSB +: S_W] = pms.s;
    end
endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LIMIT);

    AST_TIMER_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT); // R9
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_retune_pkg::*;
#(
    parameter int          LOCK_W    = 16,
    parameter int          LOCK_TIME = 20,
    parameter int          TIMEOUT   = 64,
    parameter logic [31:0] CTRL_INIT = 32'hA40C_C0F8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        level,
    input  logic [2:0]        mux_status,
    input  logic              pll_locked,
    output logic              mux_to_backup,
    output logic [15:0]       lock_count,
    output logic [31:0]       pll_ctrl,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [LOCK_W-1:0] LOCK_VAL = LOCK_W'(LOCK_TIME);
    localparam logic [LVL_W-1:0]  LVL_LIM  = LVL_W'(NUM_LEVELS);

    seq_state_t         state;
    logic [LVL_W-1:0]   lvl_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [CTRL_W-1:0]  ctrl_next;
    logic [LOCK_W-1:0]  lock_q;
    logic               sel_bk;
    logic               done_q;
    logic               err_q;
    logic               t_clear;
    logic               t_run;
    logic               t_expired;
    logic               accept;

    assign accept  = (state == ST_IDLE) && start && (level < LVL_LIM);
    assign t_clear = (state == ST_PARK) || (state == ST_PMS) || (state == ST_RETURN);
    assign t_run   = (state == ST_WAIT_BK) || (state == ST_WAIT_LOCK) ||
                     (state == ST_WAIT_MAIN);

    pll_pms_merge u_merge (
        .ctrl_in  (ctrl_q),
        .pms      (level_pms(lvl_q)),
        .ctrl_out (ctrl_next)
    );

    pll_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (t_clear),
        .run     (t_run),
        .expired (t_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            lvl_q  <= '0;
            ctrl_q <= CTRL_INIT;
            lock_q <= '0;
            sel_bk <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        lvl_q <= level;
                        err_q <= 1'b0;
                        state <= ST_PARK;
                    end
                end
                ST_PARK: begin
                    sel_bk <= 1'b1;
                    state  <= ST_WAIT_BK;
                end
                ST_WAIT_BK: begin
                    if (mux_status == MUXST_BACKUP) begin
                        state <= ST_LOCKT;
                    end else if (t_expired) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_LOCKT: begin
                    lock_q <= LOCK_VAL;
                    state  <= ST_PMS;
                end
                ST_PMS: begin
                    ctrl_q <= ctrl_next;
                    state  <= ST_WAIT_LOCK;
                end
                ST_WAIT_LOCK: begin
                    if (pll_locked) begin
                        state <= ST_RETURN;
                    end else if (t_expired) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_RETURN: begin
                    sel_bk <= 1'b0;
                    state  <= ST_WAIT_MAIN;
                end
                ST_WAIT_MAIN: begin
                    if (mux_status == MUXST_MAIN) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (t_expired) begin
                        err_q  <= 1'b1;
                        sel_bk <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mux_to_backup = sel_bk;
    assign lock_count    = 16'(lock_q);
    assign pll_ctrl      = ctrl_q;
    assign busy          = (state != ST_IDLE);
    assign done          = done_q;
    assign err           = err_q;

    AST_PMS_ONLY_PARKED: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> (sel_bk && $past(mux_status) == MUXST_BACKUP)); // R2
    AST_LOCKT_BEFORE_PMS: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> (lock_q == LOCK_VAL)); // R3
    AST_RETURN_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_bk) |-> $past(pll_locked, 2)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R6
    AST_DONE_ON_MAIN: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!sel_bk && $past(mux_status) == MUXST_MAIN)); // R6
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(lvl_q)); // R7
    AST_ERR_PARKED: assert property (@(posedge clk) disable iff (rst)
        err_q |-> sel_bk); // R9
endmodule

// File: tb/sim_pll_retune_seq.sv
module sim_pll_retune_seq;
    localparam int          LOCK_TIME = 20;
    localparam int          TIMEOUT   = 64;
    localparam logic [31:0] CTRL_INIT = 32'hA40C_C0F8;
    localparam logic [31:0] FMASK     = 32'h03FF_3F07;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  level = 3'd0;
    logic [2:0]  mux_status;
    logic        pll_locked;
    logic        mux_to_backup;
    logic [15:0] lock_count;
    logic [31:0] pll_ctrl;
    logic        busy, done, err;

    logic        stuck_mux  = 1'b0;
    logic        stuck_lock = 1'b0;
    logic [2:0]  mux_pipe;
    logic [31:0] seen_ctrl;
    logic [15:0] lk_cnt;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_ctrl;

    always #2.5 clk = ~clk;

    pll_retune_seq #(.LOCK_TIME(LOCK_TIME), .TIMEOUT(TIMEOUT), .CTRL_INIT(CTRL_INIT)) u0 (
        .clk(clk), .rst(rst), .start(start), .level(level),
        .mux_status(mux_status), .pll_locked(pll_locked),
        .mux_to_backup(mux_to_backup), .lock_count(lock_count), .pll_ctrl(pll_ctrl),
        .busy(busy), .done(done), .err(err)
    );

    // Stub mux: two-cycle readback delay, 1 = main, 2 = backup.
    always_ff @(posedge clk) begin
        if (rst) begin
            mux_pipe   <= 3'd1;
            mux_status <= 3'd1;
        end else begin
            mux_pipe   <= mux_to_backup ? 3'd2 : 3'd1;
            mux_status <= stuck_mux ? 3'd0 : mux_pipe;
        end
    end

    // Stub PLL: lock drops as soon as the control word changes.
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_ctrl <= CTRL_INIT;
            lk_cnt    <= '0;
        end else if (pll_ctrl != seen_ctrl) begin
            seen_ctrl <= pll_ctrl;
            lk_cnt    <= lock_count;
        end else if (lk_cnt != 0) begin
            lk_cnt <= lk_cnt - 1'b1;
        end
    end
    assign pll_locked = !stuck_lock && (pll_ctrl == seen_ctrl) && (lk_cnt == 0);

    // Ordering monitors.
    logic [31:0] prev_ctrl;
    logic        prev_sel;
    logic        prev_lock;
    int          order_bad, lockt_bad, lock_bad;
    always @(negedge clk) begin
        if (!rst) begin
            if (pll_ctrl != prev_ctrl && (mux_status != 3'd2 || !mux_to_backup)) order_bad++;
            if (pll_ctrl != prev_ctrl && lock_count != 16'(LOCK_TIME)) lockt_bad++;
            if (prev_sel && !mux_to_backup && !prev_lock) lock_bad++;
        end
        prev_ctrl = pll_ctrl;
        prev_sel  = mux_to_backup;
        prev_lock = pll_locked;
    end

    function automatic logic [31:0] exp_ctrl(input logic [31:0] prev, input int lvl);
        int m, p, s;
        case (lvl)
            0: begin m = 150; p = 3; s = 1; end
            1: begin m = 250; p = 6; s = 1; end
            2: begin m = 200; p = 6; s = 1; end
            3: begin m = 250; p = 6; s = 2; end
            default: begin m = 200; p = 6; s = 3; end
        endcase
        return (prev & ~FMASK) | (32'(m) << 16) | (32'(p) << 8) | 32'(s);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [2:0] lvl);
        @(negedge clk);
        start = 1'b1;
        level = lvl;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Run one sequence; poke issues a second start while busy (R7).
    task automatic run_ok(input int lvl, input bit poke);
        int dn = 0;
        int n  = 0;
        bit fin = 0;
        order_bad = 0; lockt_bad = 0; lock_bad = 0;
        pulse_start(3'(lvl));
        chk("R6 busy after accept", 32'(busy), 32'd1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; level = (lvl == 4) ? 3'd0 : 3'd4;
            @(negedge clk);
            start = 1'b0;
        end
        while (!fin && n < 3000) begin
            @(negedge clk);
            n++;
            if (done) dn++;
            else if (dn > 0) fin = 1;
        end
        if (n >= 3000) begin
            errors++; checks++;
            $display("FAIL R6 watchdog actual=no_done expected=done");
        end
        model_ctrl = exp_ctrl(model_ctrl, lvl);
        chk(poke ? "R7 level kept while busy" : "R4 pll word", pll_ctrl, model_ctrl);
        chk("R6 done width", 32'(dn), 32'd1);
        chk("R6 busy low at end", 32'(busy), 32'd0);
        chk("R5 core back on main", 32'(mux_to_backup), 32'd0);
        chk("R9 err clear", 32'(err), 32'd0);
        chk("R2 pll word only while parked", 32'(order_bad), 32'd0);
        chk("R3 lock time before pll word", 32'(lockt_bad), 32'd0);
        chk("R5 return only after lock", 32'(lock_bad), 32'd0);
        chk("R3 lock count value", 32'(lock_count), 32'(LOCK_TIME));
    endtask

    task automatic run_fail(input int lvl, input bit pll_written);
        int n = 0;
        pulse_start(3'(lvl));
        while (!(err && !busy) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R9 err raised", 32'(err), 32'd1);
        chk("R9 left on backup", 32'(mux_to_backup), 32'd1);
        chk("R9 idle after timeout", 32'(busy), 32'd0);
        if (pll_written) model_ctrl = exp_ctrl(model_ctrl, lvl);
        chk("R9 pll word after timeout", pll_ctrl, model_ctrl);
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_ctrl = CTRL_INIT;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 err", 32'(err), 32'd0);
        chk("R1 mux", 32'(mux_to_backup), 32'd0);
        chk("R1 lock count", 32'(lock_count), 32'd0);
        chk("R1 pll word", pll_ctrl, CTRL_INIT);

        // Directed: every level, then transitions between neighbours.
        for (int i = 0; i < 5; i++) run_ok(i, 1'b0);
        run_ok(3, 1'b0);
        run_ok(1, 1'b0);
        chk("R4 other bits kept", pll_ctrl & ~FMASK, CTRL_INIT & ~FMASK);

        // R7: start while busy ignored.
        run_ok(0, 1'b1);
        run_ok(4, 1'b1);

        // R8: out-of-range levels ignored.
        for (int k = 5; k < 8; k++) begin
            pulse_start(3'(k));
            repeat (4) @(negedge clk);
            chk("R8 no busy for bad level", 32'(busy), 32'd0);
            chk("R8 pll word unchanged", pll_ctrl, model_ctrl);
            chk("R8 mux unchanged", 32'(mux_to_backup), 32'd0);
        end

        // R9: stuck mux status, then stuck lock, then recovery.
        stuck_mux = 1'b1;
        run_fail(2, 1'b0);
        stuck_mux = 1'b0;
        stuck_lock = 1'b1;
        run_fail(3, 1'b1);
        stuck_lock = 1'b0;
        run_ok(2, 1'b0);

        // Constrained random levels.
        for (int r = 0; r < 20; r++) run_ok(int'($urandom_range(0, 4)), 1'b0);
        chk("R4 other bits kept after random", pll_ctrl & ~FMASK, CTRL_INIT & ~FMASK);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule